// File: doc/BRIEF.md
# Message-Triggered Horizontal Microcode Sequencer

This unit is the control block of a processing element that has no program counter and no instruction store of its own. It waits, doing nothing, until a transfer arrives. Each transfer carries a pointer and a data word. The pointer is the entry address of a straight-line macro operation held in a writable microcode RAM. Once the transfer is taken, the unit reads one horizontal control word per cycle from consecutive addresses and drives it onto the datapath control bus. It stops after the word whose end flag is set. Jumps and conditions do not exist. The data word stays frozen on the datapath inputs for the whole run.

While the run is in progress, the datapath may raise a result strobe. The unit then records the result value and a pointer for the next transfer. When the run finishes, the recorded pair is offered as an outgoing transfer on a valid/ready handshake. It is held there until the receiver accepts it, and the unit then goes back to idle. If that outgoing pointer is routed back to this unit's own input, the element drives itself step by step, much like a conventional sequential processor. The microcode RAM can be rewritten while the unit is idle.

Top module: `mseq_unit`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `dp_busy` is 0 and `dp_ctrl` is 0. The microcode RAM contents are all zero.
- R2: `in_ready` is 1 only while the unit is idle. A transfer is taken on a clock edge where `in_valid` and `in_ready` are both 1. While the unit is running or offering an output, `in_valid` has no effect.
- R3: In the cycle after a transfer is taken, `dp_busy` is 1 and `dp_ctrl` shows bits 7:0 of the microcode word at `in_ptr`. In each following busy cycle the address steps up by one, and it wraps from the top address back to 0.
- R4: A microcode word is 9 bits wide. Bit 8 is the end flag and bits 7:0 are the control word. A run lasts exactly as many cycles as there are words from the entry address up to and including the first word with bit 8 set.
- R5: For every busy cycle, `dp_data` equals the `in_data` taken with the transfer, whatever `in_data` does afterwards.
- R6: When `dp_res_we` is 1 in a busy cycle, the unit records `dp_result` and `dp_next_ptr`. The last strobe of a run wins. If a run has no strobe, both outgoing fields are 0.
- R7: `out_valid` rises in the cycle after the last busy cycle. It stays 1, with `out_data` and `out_ptr` unchanged, until a clock edge where `out_ready` is 1. After that edge the unit is idle.
- R8: A RAM write (`uc_we`, `uc_addr`, `uc_wdata`, with the word laid out as in R4) changes the RAM only if the unit is idle at that edge. A write attempted while the unit is running or offering an output leaves the RAM unchanged.
- R9: `dp_ctrl` is 0 in every cycle where `dp_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming transfer present |
| in_ready | output | 1 | Unit idle and able to take a transfer |
| in_ptr | input | 4 | Entry address of the macro operation |
| in_data | input | 16 | Data part of the incoming transfer |
| uc_we | input | 1 | Microcode write strobe |
| uc_addr | input | 4 | Microcode write address |
| uc_wdata | input | 9 | Microcode word: end flag in bit 8, control in bits 7:0 |
| dp_busy | output | 1 | Control word on `dp_ctrl` is live this cycle |
| dp_ctrl | output | 8 | Horizontal control word to the datapath |
| dp_data | output | 16 | Held data operand for the datapath |
| dp_res_we | input | 1 | Datapath result strobe |
| dp_result | input | 16 | Datapath result value |
| dp_next_ptr | input | 4 | Pointer for the outgoing transfer |
| out_valid | output | 1 | Outgoing transfer offered |
| out_ready | input | 1 | Receiver takes the outgoing transfer |
| out_data | output | 16 | Data part of the outgoing transfer |
| out_ptr | output | 4 | Pointer part of the outgoing transfer |

## Verification
Some properties are checked on every cycle by the assertions. A taken transfer always starts a busy cycle. The held operand stays stable across busy cycles. A stalled output stays valid and unchanged. No input is accepted while an output is being offered. No control word leaks out while the unit is idle.

Other properties can only be shown by the bench's scenarios:
- the exact control-word sequence that consecutive addressing and wrap-around produce;
- run lengths set by the end flag;
- the rule that the last result strobe wins, and the zero result when no strobe occurs;
- writes that are dropped while busy, compared with writes that take effect while idle.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SEND = 2'd2
    } mseq_state_e;
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
    parameter int WORD_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mseq_fsm.sv
module mseq_fsm
    import mseq_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PTR_W-1:0]  in_ptr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              word_last,
    input  logic              out_ready,
    output logic              idle,
    output logic              busy,
    output logic              sending,
    output logic              accept,
    output logic [PTR_W-1:0]  pc,
    output logic [DATA_W-1:0] held_data
);
    typedef struct packed {
        mseq_state_e       st;
        logic [PTR_W-1:0]  pc;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.st   = ST_RUN;
                    r_d.pc   = in_ptr;
                    r_d.data = in_data;
                end
            end
            ST_RUN: begin
                if (word_last) begin
                    r_d.st = ST_SEND;
                end else begin
                    r_d.pc = r_q.pc + 1'b1;
                end
            end
            ST_SEND: begin
                if (out_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pc: '0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign idle      = (r_q.st == ST_IDLE);
    assign busy      = (r_q.st == ST_RUN);
    assign sending   = (r_q.st == ST_SEND);
    assign accept    = idle && in_valid;
    assign pc        = r_q.pc;
    assign held_data = r_q.data;

    AST_RUN_STEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !word_last |=> busy && (pc == $past(pc) + 1'b1)) else $error("pc step"); // R3
endmodule

// File: rtl/mseq_bundle.sv
module mseq_bundle #(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] result,
    input  logic [PTR_W-1:0]  next_ptr,
    output logic [DATA_W-1:0] res_data,
    output logic [PTR_W-1:0]  res_ptr
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [PTR_W-1:0]  ptr;
    } bundle_t;

    bundle_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr) begin
            b_d = '0;
        end else if (cap_en) begin
            b_d.data = result;
            b_d.ptr  = next_ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign res_data = b_q.data;
    assign res_ptr  = b_q.ptr;
endmodule

// File: rtl/mseq_unit.sv
module mseq_unit #(
    parameter int PTR_W  = 4,
    parameter int CTRL_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PTR_W-1:0]  in_ptr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              uc_we,
    input  logic [PTR_W-1:0]  uc_addr,
    input  logic [CTRL_W:0]   uc_wdata,
    output logic              dp_busy,
    output logic [CTRL_W-1:0] dp_ctrl,
    output logic [DATA_W-1:0] dp_data,
    input  logic              dp_res_we,
    input  logic [DATA_W-1:0] dp_result,
    input  logic [PTR_W-1:0]  dp_next_ptr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [PTR_W-1:0]  out_ptr
);
    localparam int WORD_W = CTRL_W + 1;
    localparam int LAST_B = CTRL_W;

    logic              idle, busy, sending, accept;
    logic [PTR_W-1:0]  pc;
    logic [WORD_W-1:0] word;
    logic              word_last;

    mseq_store #(.WORD_W(WORD_W), .ADDR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (uc_we && idle),
        .wr_addr (uc_addr),
        .wr_data (uc_wdata),
        .rd_addr (pc),
        .rd_data (word)
    );

    assign word_last = busy && word[LAST_B];

    mseq_fsm #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ptr    (in_ptr),
        .in_data   (in_data),
        .word_last (word_last),
        .out_ready (out_ready),
        .idle      (idle),
        .busy      (busy),
        .sending   (sending),
        .accept    (accept),
        .pc        (pc),
        .held_data (dp_data)
    );

    mseq_bundle #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_bundle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .cap_en   (busy && dp_res_we),
        .result   (dp_result),
        .next_ptr (dp_next_ptr),
        .res_data (out_data),
        .res_ptr  (out_ptr)
    );

    assign in_ready  = idle;
    assign dp_busy   = busy;
    assign dp_ctrl   = busy ? word[CTRL_W-1:0] : '0;
    assign out_valid = sending;

    AST_ACCEPT_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> dp_busy) else $error("no run after accept"); // R3
    AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dp_busy |=> !dp_busy || $stable(dp_data)) else $error("operand moved"); // R5
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ptr)) else $error("output dropped"); // R7
    AST_NO_TAKE_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready) else $error("accept while offering"); // R2
    AST_QUIET_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_busy |-> (dp_ctrl == '0)) else $error("ctrl leak"); // R9
endmodule

// File: tb/mseq_unit_bench.sv
module mseq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_ptr = '0;
    logic [15:0] in_data = '0;
    logic        uc_we = 1'b0;
    logic [3:0]  uc_addr = '0;
    logic [8:0]  uc_wdata = '0;
    logic        dp_busy;
    logic [7:0]  dp_ctrl;
    logic [15:0] dp_data;
    logic        dp_res_we;
    logic [15:0] dp_result;
    logic [3:0]  dp_next_ptr;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic [3:0]  out_ptr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [8:0] prog [16];

    always #4 clk = ~clk;

    // Bench datapath model: strobe on control bit 0, result = operand ^ control
    assign dp_res_we   = dp_busy & dp_ctrl[0];
    assign dp_result   = dp_data ^ {8'h00, dp_ctrl};
    assign dp_next_ptr = dp_ctrl[7:4];

    mseq_unit u_mseq_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ptr(in_ptr), .in_data(in_data), .uc_we(uc_we), .uc_addr(uc_addr),
        .uc_wdata(uc_wdata), .dp_busy(dp_busy), .dp_ctrl(dp_ctrl), .dp_data(dp_data),
        .dp_res_we(dp_res_we), .dp_result(dp_result), .dp_next_ptr(dp_next_ptr),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ptr(out_ptr)
    );

    localparam int NV = 5;
    localparam logic [3:0]  V_PTR [NV] = '{4'd0, 4'd1, 4'd4, 4'd6, 4'd15};
    localparam logic [15:0] V_DAT [NV] = '{16'h1234, 16'hAAAA, 16'h0F0F, 16'hFFFF, 16'h5555};
    localparam int          V_LEN [NV] = '{1, 3, 2, 1, 2};
    localparam logic [15:0] V_OUT [NV] = '{16'h1205, 16'hAA8F, 16'h0F6C, 16'h0000, 16'h5564};
    localparam logic [3:0]  V_OPT [NV] = '{4'd3, 4'd2, 4'd6, 4'd0, 4'd3};

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            report();
        end
    end

    task automatic write_word(input logic [3:0] a, input logic [8:0] w);
        @(negedge clk);
        uc_we = 1'b1; uc_addr = a; uc_wdata = w;
        prog[a] = w;
        @(negedge clk);
        uc_we = 1'b0;
    endtask

    // Run one transfer; while busy, junk on in_data and a write attempt to address 6
    task automatic run(input logic [3:0] p, input logic [15:0] d, input int len,
                       input logic [15:0] eo, input logic [3:0] ep, input bit poke);
        int n;
        @(negedge clk);
        chk(in_ready, "R2 ready before transfer", {31'd0, in_ready}, 32'd1);
        in_valid = 1'b1; in_ptr = p; in_data = d;
        @(negedge clk);
        in_data = ~d; in_ptr = p + 4'd3;
        if (poke) begin uc_we = 1'b1; uc_addr = 4'd6; uc_wdata = 9'h1FF; end
        n = 0;
        while (dp_busy && n < 40) begin
            chk(dp_ctrl == prog[4'(p + n)][7:0], "R3 control word order", {24'd0, dp_ctrl}, {23'd0, prog[4'(p + n)]});
            chk(dp_data == d, "R5 operand held", {16'd0, dp_data}, {16'd0, d});
            chk(!in_ready, "R2 not ready while busy", {31'd0, in_ready}, 32'd0);
            n++;
            @(negedge clk);
        end
        chk(n == len, "R4 run length", n, len);
        chk(dp_ctrl == 8'h00, "R9 ctrl quiet after run", {24'd0, dp_ctrl}, 32'd0);
        chk(out_valid, "R7 output offered", {31'd0, out_valid}, 32'd1);
        chk(out_data == eo, "R6 result data", {16'd0, out_data}, {16'd0, eo});
        chk(out_ptr == ep, "R6 result pointer", {28'd0, out_ptr}, {28'd0, ep});
        @(negedge clk);
        chk(out_valid && out_data == eo && out_ptr == ep, "R7 held while stalled", {16'd0, out_data}, {16'd0, eo});
        chk(!in_ready, "R2 in_valid ignored while offering", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b0; uc_we = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && in_ready && !dp_busy, "R7 idle after handoff", {30'd0, out_valid, in_ready}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) prog[i] = 9'h000;
        #2;
        chk(in_ready == 1'b1, "R1 reset in_ready", {31'd0, in_ready}, 32'd1);
        chk(!out_valid && !dp_busy && dp_ctrl == 8'h00, "R1 reset outputs", {30'd0, out_valid, dp_busy}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // An all-zero RAM (R1): entry 9 has no end flag until its neighbours run on
        write_word(4'd0, 9'h131);
        write_word(4'd1, 9'h010);
        write_word(4'd2, 9'h025);
        write_word(4'd3, 9'h140);
        write_word(4'd4, 9'h051);
        write_word(4'd5, 9'h163);
        write_word(4'd6, 9'h102);
        write_word(4'd15, 9'h071);

        // Table walk; each run attempts a busy write to address 6 (R8)
        for (int v = 0; v < NV; v++) begin
            run(V_PTR[v], V_DAT[v], V_LEN[v], V_OUT[v], V_OPT[v], 1'b1);
        end

        // R8: an idle write does take effect
        write_word(4'd6, 9'h181);
        run(4'd6, 16'h00F0, 1, 16'h0071, 4'd8, 1'b0);

        // R6: the last strobe of a run wins (words 7,8 strobe; 8 ends)
        write_word(4'd7, 9'h093);
        write_word(4'd8, 9'h1A5);
        run(4'd7, 16'h1000, 2, 16'h10A5, 4'hA, 1'b0);

        // R1: RAM reads zero after reset (entry 9..14 zero, 15 written) -> run 9..0 wraps
        run(4'd9, 16'h2222, 8, 16'h2213, 4'd3, 1'b0);

        report();
    end
endmodule